// File: doc/BRIEF.md
# Byte-Addressed Controller for a Word-Organized Three-Wire Serial EEPROM

This block is a bus master for a three-wire serial EEPROM that stores 64 words of 16 bits. Toward the host it looks like a 128-byte memory. The host starts a request with a read or write direction, a starting byte offset and a byte count. The controller then works through the bytes one at a time in ascending order. For a read, each byte appears on a data output together with a one-cycle valid strobe. For a write, the controller shows the offset it is handling on `byte_pos`, and the host must present the matching byte on `wdata`.

Because the device can only store whole words, each byte write reads the containing word, replaces one half of it and writes the merged word back. After each word write the controller waits for the device to finish its internal programming. It does this by reselecting the device and watching the returned data line. A write request is bracketed by a write-unlock command before the first byte and a write-lock command after the last byte. If the device stays busy too long, the controller abandons the remaining bytes, re-locks the device and reports an error. A request that would reach past the end of the 128 bytes is refused at once, and no serial traffic is sent.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, `cs`, `sck` and `mosi` are low, and `done`, `rvalid` and `err` are low.
- R2: A request with offset ≥ 128, or with offset + count > 128, makes `done` and `err` high in the first cycle after the request is sampled. No chip-select window is opened for it.
- R3: A read returns `count` bytes in ascending offset order, each with a one-cycle `rvalid`. The byte at offset o comes from word o>>1: an odd o gives bits [15:8] and an even o gives bits [7:0].
- R4: Each command starts with a 1 bit, followed by a 2-bit opcode and a 6-bit word address, sent MSB first. The opcodes are: read = 10, write = 01, unlock = 00 with address 11xxxx, lock = 00 with address 00xxxx.
- R5: A read window lasts 26 clock pulses: 9 command bits, one discarded dummy bit, then data bits 15 down to 0.
- R6: A byte write changes only its target byte. The other byte of the same word keeps its earlier value, because the word is read, merged and then written.
- R7: Each write request with count > 0 sends exactly one unlock window before its first word write and exactly one lock window after its last word write.
- R8: After the 16 data bits of a write, `cs` drops and then rises again. The controller holds `cs` high until `miso` reads 1, then drops `cs`. No new command starts while the device is still busy.
- R9: If `miso` stays low for POLL_LIMIT cycles during that wait, the controller sets `err`, skips the remaining bytes, still sends the lock window, and then pulses `done`.
- R10: `done` is high for exactly one cycle per request. `err` is cleared when the next request is accepted.
- R11: `cs` is active high. Whenever `cs` is low, `sck` and `mosi` are low. `mosi` changes only while `sck` is low. Each `sck` level lasts DIV cycles.
- R12: A valid request with count 0 pulses `done` with `err` low and opens no chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while the block is idle |
| wr_sel | input | 1 | 1 = write request, 0 = read request |
| offset | input | 8 | Starting byte offset |
| count | input | 8 | Number of bytes to move |
| wdata | input | 8 | Write byte for the offset shown on `byte_pos` |
| byte_pos | output | 8 | Byte offset currently being processed |
| rdata | output | 8 | Read byte |
| rvalid | output | 1 | One-cycle strobe marking `rdata` as valid |
| done | output | 1 | One-cycle pulse when the request ends |
| err | output | 1 | Error flag for the last request (range refused or busy timeout) |
| cs | output | 1 | Device chip select, active high |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data and ready/busy status from the device |

## Verification
The assertions assume that `req` is raised only while the controller is idle. They also assume that `miso` is driven only by a device that changes it on falling `sck` edges or from its busy state. The bench pulses `req` only after the previous `done` has been seen. Its device model changes its output only on falling clock edges or on chip-select changes. The model also checks the command format, the frame lengths and the unlock state. It records any command that starts while the device is still programming. For the timeout case, the bench holds the model busy for longer than the poll limit, and turns off the busy-collision check only for that case.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    localparam int MW_AW      = 6;
    localparam int MW_DW      = 16;
    localparam int MW_FRAME_W = 26;
    localparam int MW_BYTES   = 2 * (1 << MW_AW);

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_CTRL  = 2'b00;

    localparam logic [4:0] LEN_CTRL  = 5'd9;
    localparam logic [4:0] LEN_WRITE = 5'd25;
    localparam logic [4:0] LEN_READ  = 5'd26;

    typedef enum logic [2:0] {
        E_IDLE, E_LO, E_HI, E_TAIL, E_DESEL, E_POLL
    } eng_st_e;

    typedef enum logic [2:0] {
        S_IDLE, S_UNLOCK, S_FETCH, S_STORE, S_WAIT, S_LOCK
    } seq_st_e;

    function automatic logic [MW_FRAME_W-1:0] frm_read(input logic [MW_AW-1:0] a);
        return {1'b1, OPC_READ, a, 17'b0};
    endfunction

    function automatic logic [MW_FRAME_W-1:0] frm_write(input logic [MW_AW-1:0] a,
                                                        input logic [MW_DW-1:0] w);
        return {1'b1, OPC_WRITE, a, w, 1'b0};
    endfunction

    function automatic logic [MW_FRAME_W-1:0] frm_ctrl(input logic unlock);
        return {1'b1, OPC_CTRL, {2{unlock}}, 4'b0, 17'b0};
    endfunction
endpackage

// File: rtl/mw_span_chk.sv
`timescale 1ns/1ps
module mw_span_chk
    import mw_pkg::*;
(
    input  logic [7:0] offset,
    input  logic [7:0] count,
    output logic       ok
);
    localparam logic [8:0] LIMIT = 9'(MW_BYTES);
    logic [8:0] span_end;

    always_comb begin
        span_end = {1'b0, offset} + {1'b0, count};
        ok       = ({1'b0, offset} < LIMIT) && (span_end <= LIMIT);
    end
endmodule

// File: rtl/mw_frame_eng.sv
`timescale 1ns/1ps
module mw_frame_eng
    import mw_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int POLL_LIMIT = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  poll,
    input  logic [4:0]            nbits,
    input  logic [MW_FRAME_W-1:0] tx,
    input  logic                  miso,
    output logic                  cs,
    output logic                  sck,
    output logic                  mosi,
    output logic                  fin,
    output logic                  tmo,
    output logic [MW_DW-1:0]      rx
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int TW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
    localparam logic [TW-1:0] T_LAST   = TW'(POLL_LIMIT - 1);

    typedef struct packed {
        eng_st_e               st;
        logic                  cs;
        logic                  sck;
        logic                  mosi;
        logic                  fin;
        logic                  tmo;
        logic [MW_FRAME_W-1:0] sh;
        logic [4:0]            left;
        logic [CW-1:0]         cnt;
        logic [TW-1:0]         tcnt;
        logic [MW_DW-1:0]      rx;
    } eng_t;

    eng_t eng_q, eng_d;
    logic tick;

    always_comb begin
        eng_d     = eng_q;
        eng_d.fin = 1'b0;
        tick      = (eng_q.cnt == CNT_LAST);
        case (eng_q.st)
            E_IDLE: begin
                if (go) begin
                    eng_d.tmo = 1'b0;
                    eng_d.cs  = 1'b1;
                    eng_d.cnt = '0;
                    if (poll) begin
                        eng_d.tcnt = '0;
                        eng_d.st   = E_POLL;
                    end else begin
                        eng_d.sh   = tx;
                        eng_d.mosi = tx[MW_FRAME_W-1];
                        eng_d.left = nbits;
                        eng_d.rx   = '0;
                        eng_d.st   = E_LO;
                    end
                end
            end
            E_LO: begin
                if (tick) begin
                    eng_d.cnt = '0;
                    eng_d.sck = 1'b1;
                    eng_d.rx  = {eng_q.rx[MW_DW-2:0], miso};
                    eng_d.st  = E_HI;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            E_HI: begin
                if (tick) begin
                    eng_d.cnt = '0;
                    eng_d.sck = 1'b0;
                    if (eng_q.left == 5'd1) begin
                        eng_d.mosi = 1'b0;
                        eng_d.st   = E_TAIL;
                    end else begin
                        eng_d.sh   = eng_q.sh << 1;
                        eng_d.mosi = eng_q.sh[MW_FRAME_W-2];
                        eng_d.left = eng_q.left - 5'd1;
                        eng_d.st   = E_LO;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            E_TAIL: begin
                if (tick) begin
                    eng_d.cnt = '0;
                    eng_d.cs  = 1'b0;
                    eng_d.st  = E_DESEL;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            E_DESEL: begin
                if (tick) begin
                    eng_d.cnt = '0;
                    eng_d.fin = 1'b1;
                    eng_d.st  = E_IDLE;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            E_POLL: begin
                if (miso) begin
                    eng_d.st = E_TAIL;
                end else if (eng_q.tcnt == T_LAST) begin
                    eng_d.tmo = 1'b1;
                    eng_d.st  = E_TAIL;
                end else begin
                    eng_d.tcnt = eng_q.tcnt + 1'b1;
                end
            end
            default: eng_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign cs   = eng_q.cs;
    assign sck  = eng_q.sck;
    assign mosi = eng_q.mosi;
    assign fin  = eng_q.fin;
    assign tmo  = eng_q.tmo;
    assign rx   = eng_q.rx;
endmodule

// File: rtl/mw_byte_seq.sv
`timescale 1ns/1ps
module mw_byte_seq
    import mw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  wr_sel,
    input  logic [7:0]            offset,
    input  logic [7:0]            count,
    input  logic [7:0]            wdata,
    input  logic                  span_ok,
    input  logic                  eng_fin,
    input  logic                  eng_tmo,
    input  logic [MW_DW-1:0]      eng_rx,
    output logic                  eng_go,
    output logic                  eng_poll,
    output logic [4:0]            eng_nbits,
    output logic [MW_FRAME_W-1:0] eng_tx,
    output logic [7:0]            byte_pos,
    output logic [7:0]            rdata,
    output logic                  rvalid,
    output logic                  done,
    output logic                  err,
    output logic                  at_rest
);
    typedef struct packed {
        seq_st_e               st;
        logic [7:0]            off;
        logic [7:0]            left;
        logic                  wr;
        logic                  err;
        logic                  done;
        logic                  rvalid;
        logic [7:0]            rdata;
        logic                  go;
        logic                  poll;
        logic [4:0]            nbits;
        logic [MW_FRAME_W-1:0] tx;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [7:0]       nxt_off;
    logic [MW_DW-1:0] merged;

    always_comb begin
        seq_d        = seq_q;
        seq_d.go     = 1'b0;
        seq_d.poll   = 1'b0;
        seq_d.done   = 1'b0;
        seq_d.rvalid = 1'b0;
        nxt_off      = seq_q.off + 8'd1;
        merged       = seq_q.off[0] ? {wdata, eng_rx[7:0]} : {eng_rx[15:8], wdata};
        case (seq_q.st)
            S_IDLE: begin
                if (req) begin
                    seq_d.err  = 1'b0;
                    seq_d.off  = offset;
                    seq_d.left = count;
                    seq_d.wr   = wr_sel;
                    if (!span_ok) begin
                        seq_d.err  = 1'b1;
                        seq_d.done = 1'b1;
                    end else if (count == 8'd0) begin
                        seq_d.done = 1'b1;
                    end else if (wr_sel) begin
                        seq_d.go    = 1'b1;
                        seq_d.nbits = LEN_CTRL;
                        seq_d.tx    = frm_ctrl(1'b1);
                        seq_d.st    = S_UNLOCK;
                    end else begin
                        seq_d.go    = 1'b1;
                        seq_d.nbits = LEN_READ;
                        seq_d.tx    = frm_read(offset[MW_AW:1]);
                        seq_d.st    = S_FETCH;
                    end
                end
            end
            S_UNLOCK: begin
                if (eng_fin) begin
                    seq_d.go    = 1'b1;
                    seq_d.nbits = LEN_READ;
                    seq_d.tx    = frm_read(seq_q.off[MW_AW:1]);
                    seq_d.st    = S_FETCH;
                end
            end
            S_FETCH: begin
                if (eng_fin) begin
                    if (seq_q.wr) begin
                        seq_d.go    = 1'b1;
                        seq_d.nbits = LEN_WRITE;
                        seq_d.tx    = frm_write(seq_q.off[MW_AW:1], merged);
                        seq_d.st    = S_STORE;
                    end else begin
                        seq_d.rdata  = seq_q.off[0] ? eng_rx[15:8] : eng_rx[7:0];
                        seq_d.rvalid = 1'b1;
                        seq_d.left   = seq_q.left - 8'd1;
                        seq_d.off    = nxt_off;
                        if (seq_q.left == 8'd1) begin
                            seq_d.done = 1'b1;
                            seq_d.st   = S_IDLE;
                        end else begin
                            seq_d.go    = 1'b1;
                            seq_d.nbits = LEN_READ;
                            seq_d.tx    = frm_read(nxt_off[MW_AW:1]);
                        end
                    end
                end
            end
            S_STORE: begin
                if (eng_fin) begin
                    seq_d.go   = 1'b1;
                    seq_d.poll = 1'b1;
                    seq_d.st   = S_WAIT;
                end
            end
            S_WAIT: begin
                if (eng_fin) begin
                    seq_d.go = 1'b1;
                    if (eng_tmo || seq_q.left == 8'd1) begin
                        seq_d.err   = eng_tmo;
                        seq_d.nbits = LEN_CTRL;
                        seq_d.tx    = frm_ctrl(1'b0);
                        seq_d.st    = S_LOCK;
                    end else begin
                        seq_d.nbits = LEN_READ;
                        seq_d.tx    = frm_read(nxt_off[MW_AW:1]);
                        seq_d.st    = S_FETCH;
                    end
                    if (!eng_tmo) begin
                        seq_d.left = seq_q.left - 8'd1;
                        seq_d.off  = nxt_off;
                    end
                end
            end
            S_LOCK: begin
                if (eng_fin) begin
                    seq_d.done = 1'b1;
                    seq_d.st   = S_IDLE;
                end
            end
            default: seq_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign eng_go    = seq_q.go;
    assign eng_poll  = seq_q.poll;
    assign eng_nbits = seq_q.nbits;
    assign eng_tx    = seq_q.tx;
    assign byte_pos  = seq_q.off;
    assign rdata     = seq_q.rdata;
    assign rvalid    = seq_q.rvalid;
    assign done      = seq_q.done;
    assign err       = seq_q.err;
    assign at_rest   = (seq_q.st == S_IDLE);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int POLL_LIMIT = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       wr_sel,
    input  logic [7:0] offset,
    input  logic [7:0] count,
    input  logic [7:0] wdata,
    output logic [7:0] byte_pos,
    output logic [7:0] rdata,
    output logic       rvalid,
    output logic       done,
    output logic       err,
    output logic       cs,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    logic                  span_ok;
    logic                  eng_go, eng_poll, eng_fin, eng_tmo;
    logic [4:0]            eng_nbits;
    logic [MW_FRAME_W-1:0] eng_tx;
    logic [MW_DW-1:0]      eng_rx;
    logic                  at_rest;

    mw_span_chk u_span (
        .offset (offset),
        .count  (count),
        .ok     (span_ok)
    );

    mw_byte_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr_sel    (wr_sel),
        .offset    (offset),
        .count     (count),
        .wdata     (wdata),
        .span_ok   (span_ok),
        .eng_fin   (eng_fin),
        .eng_tmo   (eng_tmo),
        .eng_rx    (eng_rx),
        .eng_go    (eng_go),
        .eng_poll  (eng_poll),
        .eng_nbits (eng_nbits),
        .eng_tx    (eng_tx),
        .byte_pos  (byte_pos),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .done      (done),
        .err       (err),
        .at_rest   (at_rest)
    );

    mw_frame_eng #(
        .DIV        (DIV),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (eng_go),
        .poll  (eng_poll),
        .nbits (eng_nbits),
        .tx    (eng_tx),
        .miso  (miso),
        .cs    (cs),
        .sck   (sck),
        .mosi  (mosi),
        .fin   (eng_fin),
        .tmo   (eng_tmo),
        .rx    (eng_rx)
    );
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [7:0] offset,
    input logic [7:0] count,
    input logic       done,
    input logic       err,
    input logic       rvalid,
    input logic       cs,
    input logic       sck,
    input logic       mosi,
    input logic       at_rest
);
    logic refused;
    assign refused = offset[7] || (({1'b0, offset} + {1'b0, count}) > 9'd128);

    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && at_rest && refused) |=> (done && err)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (!sck && !mosi)); // R11
    AST_MOSI_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R11
    AST_SELECT_WITH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> !sck); // R11
    AST_RVALID_IN_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!at_rest)); // R3
    AST_REST_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        at_rest |-> !cs); // R12
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .offset  (offset),
    .count   (count),
    .done    (done),
    .err     (err),
    .rvalid  (rvalid),
    .cs      (cs),
    .sck     (sck),
    .mosi    (mosi),
    .at_rest (at_rest)
);

// File: tb/mw_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_test;
    localparam int DIV   = 2;
    localparam int LIMIT = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, wr_sel = 1'b0;
    logic [7:0] offset = '0, count = '0;
    logic [7:0] wdata, byte_pos, rdata;
    logic       rvalid, done, err, cs, sck, mosi, miso;

    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    mw_eeprom_ctrl #(.DIV(DIV), .POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_sel(wr_sel), .offset(offset),
        .count(count), .wdata(wdata), .byte_pos(byte_pos), .rdata(rdata),
        .rvalid(rvalid), .done(done), .err(err), .cs(cs), .sck(sck),
        .mosi(mosi), .miso(miso)
    );

    // host-side byte source and expected contents
    logic [7:0] wbuf [128];
    logic [7:0] shadow [128];
    assign wdata = wbuf[byte_pos[6:0]];

    // serial device model
    logic [15:0] emem [64];
    logic        dout = 1'b0, inpoll = 1'b0, pend = 1'b0, we = 1'b0, stuck = 1'b0;
    int          bitcnt = 0, busy = 0, busy_len = 30;
    logic [8:0]  cmd = '0;
    logic [15:0] dat = '0, rdw = '0;
    int n_rd = 0, n_wr = 0, n_en = 0, n_dis = 0, n_bad = 0, hp_bad = 0;

    assign miso = cs ? (inpoll ? (busy == 0) : dout) : 1'b0;

    always @(posedge cs) begin
        bitcnt = 0; cmd = '0; dat = '0; dout = 1'b0;
        inpoll = pend; pend = 1'b0;
        if (busy > 0 && !inpoll && !stuck) n_bad++;
    end

    always @(negedge cs) begin
        if (!inpoll) begin
            if (!cmd[8]) n_bad++;
            case (cmd[7:6])
                2'b10: if (bitcnt != 26) n_bad++; else n_rd++;
                2'b01: if (bitcnt != 25 || !we) n_bad++;
                       else begin emem[cmd[5:0]] = dat; busy = busy_len; pend = 1'b1; n_wr++; end
                2'b00: if (bitcnt != 9) n_bad++;
                       else if (cmd[5:4] == 2'b11) begin we = 1'b1; n_en++; end
                       else if (cmd[5:4] == 2'b00) begin we = 1'b0; n_dis++; end
                       else n_bad++;
                default: n_bad++;
            endcase
        end
        inpoll = 1'b0;
    end

    always @(posedge sck) if (cs) begin
        if (inpoll) n_bad++;
        if (bitcnt < 9) cmd = {cmd[7:0], mosi};
        else if (bitcnt < 25) dat = {dat[14:0], mosi};
        bitcnt++;
        if (bitcnt == 9 && cmd[7:6] == 2'b10) rdw = emem[cmd[5:0]];
    end

    always @(negedge sck) if (cs && bitcnt >= 9 && cmd[7:6] == 2'b10) begin
        if (bitcnt == 9) dout = 1'b0;
        else if (bitcnt <= 25) dout = rdw[25-bitcnt];
    end

    always @(posedge clk) if (busy > 0) busy = busy - 1;

    // sck half-period monitor (R11)
    int   hp_cnt = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        if (!cs) hp_cnt <= 0;
        else if (sck != sck_prev) begin
            if (hp_cnt != DIV) hp_bad <= hp_bad + 1;
            hp_cnt <= 1;
        end else hp_cnt <= hp_cnt + 1;
        sck_prev <= sck;
    end

    // scoreboard
    logic [7:0] exp_q [$];
    int         nvalid = 0;
    always @(negedge clk) if (rvalid) begin
        nvalid++;
        nchk++;
        if (exp_q.size() == 0) begin
            nerr++;
            $display("FAIL R3: unexpected rvalid, actual %02h expected none", rdata);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            if (rdata !== e) begin
                nerr++;
                $display("FAIL R3/R5: read byte actual %02h expected %02h", rdata, e);
            end
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    int done_wait;
    task automatic issue(input logic w, input int off, input int cnt);
        @(negedge clk);
        req = 1'b1; wr_sel = w; offset = 8'(off); count = 8'(cnt);
        @(negedge clk);
        req = 1'b0;
        done_wait = 0;
        while (!done && done_wait < 40000) begin
            @(negedge clk);
            done_wait++;
        end
        if (!done) begin
            nerr++;
            $display("FAIL R10: done never seen, actual 0 expected 1");
        end
    endtask

    task automatic do_read(input int off, input int cnt);
        for (int i = 0; i < cnt; i++) exp_q.push_back(shadow[off+i]);
        nvalid = 0;
        issue(1'b0, off, cnt);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
        chk(nvalid == cnt, "R3 rvalid count", nvalid, cnt);
        exp_q.delete();
    endtask

    task automatic load_bytes(input int off, input int cnt, input int seed);
        for (int i = 0; i < cnt; i++) wbuf[off+i] = 8'(seed + i * 29);
    endtask

    task automatic commit_shadow(input int off, input int cnt);
        for (int i = 0; i < cnt; i++) shadow[off+i] = wbuf[off+i];
    endtask

    task automatic cmp_words(input string r);
        int bad = 0;
        for (int w = 0; w < 64; w++)
            if (emem[w] !== {shadow[2*w+1], shadow[2*w]}) bad++;
        chk(bad == 0, r, bad, 0);
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        int r0, w0, e0, d0;
        for (int w = 0; w < 64; w++) begin
            shadow[2*w]   = 8'(w * 7 + 3);
            shadow[2*w+1] = 8'(w * 11 + 8'h40);
            emem[w] = {shadow[2*w+1], shadow[2*w]};
        end
        for (int i = 0; i < 128; i++) wbuf[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!cs && !sck && !mosi, "R1 serial lines idle", {cs, sck, mosi}, 0);
        chk(!done && !rvalid && !err, "R1 host flags idle", {done, rvalid, err}, 0);
        rst_n = 1'b1;

        // R3 R5 reads
        r0 = n_rd;
        do_read(0, 4);
        chk(n_rd - r0 == 4, "R5 one read window per byte", n_rd - r0, 4);
        do_read(5, 3);
        do_read(127, 1);
        do_read(120, 8);

        // R6 R7 single-byte write
        r0 = n_wr; e0 = n_en; d0 = n_dis;
        load_bytes(9, 1, 8'h5A);
        issue(1'b1, 9, 1);
        commit_shadow(9, 1);
        chk(err == 1'b0, "R6 write no error", err, 0);
        chk(emem[4] === {shadow[9], shadow[8]}, "R6 neighbour byte kept", emem[4], {shadow[9], shadow[8]});
        chk(n_en - e0 == 1 && n_dis - d0 == 1, "R7 one unlock and one lock", (n_en - e0) * 10 + n_dis - d0, 11);
        chk(n_wr - r0 == 1, "R6 one word write", n_wr - r0, 1);
        chk(we == 1'b0, "R7 device relocked", we, 0);

        // R6 R7 multi-byte write across words
        r0 = n_wr; e0 = n_en; d0 = n_dis;
        load_bytes(20, 5, 8'hC1);
        issue(1'b1, 20, 5);
        commit_shadow(20, 5);
        chk(n_wr - r0 == 5, "R6 word write per byte", n_wr - r0, 5);
        chk(n_en - e0 == 1 && n_dis - d0 == 1, "R7 burst wrapped once", (n_en - e0) * 10 + n_dis - d0, 11);
        cmp_words("R6 memory image after writes");
        do_read(19, 8);

        // R2 range refusals
        r0 = n_rd + n_wr + n_en + n_dis;
        issue(1'b0, 128, 1);
        chk(done_wait == 0 && err, "R2 offset 128 refused next cycle", done_wait * 2 + err, 1);
        issue(1'b1, 120, 9);
        chk(done_wait == 0 && err, "R2 span past end refused", done_wait * 2 + err, 1);
        issue(1'b0, 200, 0);
        chk(err == 1'b1, "R2 offset 200 refused", err, 1);
        chk(n_rd + n_wr + n_en + n_dis == r0, "R2 no serial traffic", n_rd + n_wr + n_en + n_dis, r0);

        // R12 zero count, also clears err (R10)
        issue(1'b1, 10, 0);
        chk(err == 1'b0, "R12 zero count no error / R10 err cleared", err, 0);
        chk(n_rd + n_wr + n_en + n_dis == r0, "R12 no serial traffic", n_rd + n_wr + n_en + n_dis, r0);

        // R9 busy timeout
        stuck = 1'b1; busy_len = 5000;
        r0 = n_wr; d0 = n_dis;
        load_bytes(2, 3, 8'h77);
        issue(1'b1, 2, 3);
        commit_shadow(2, 1);
        chk(err == 1'b1, "R9 timeout flags error", err, 1);
        chk(n_wr - r0 == 1, "R9 remaining bytes skipped", n_wr - r0, 1);
        chk(n_dis - d0 == 1 && we == 1'b0, "R9 lock still sent", n_dis - d0, 1);
        cmp_words("R9 only first byte stored");
        busy = 0; busy_len = 30; stuck = 1'b0;

        // R10 err clears on next request, done is single-cycle
        do_read(2, 3);
        chk(err == 1'b0, "R10 err cleared by next request", err, 0);
        chk(done == 1'b0, "R10 done lasts one cycle", done, 0);

        // R4 R8 R11 protocol monitors
        chk(n_bad == 0, "R4/R8 command format and busy rule", n_bad, 0);
        chk(hp_bad == 0, "R11 sck half-period", hp_bad, 0);
        chk(!cs && !sck && !mosi, "R11 lines idle after run", {cs, sck, mosi}, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule